// File: doc/BRIEF.md
# Quadrant Almost-Empty Status Bus Driver

This block lets several queue devices share one narrow almost-empty status bus. Each device holds a number of queues, grouped into quadrants of eight. A selection word, strobed on the read clock, names one device and one of its quadrants. The named device drives the eight per-queue almost-empty bits of that quadrant onto the shared bus. Every other device keeps its drivers in high-impedance.

The per-queue almost-empty flags come in from the surrounding queue logic. This block only decodes the selection, hands bus ownership from one device to the next, and keeps the bus bits current. A captured selection takes effect one read-clock cycle later. Until then the bus keeps showing the quadrant that was loaded before. In the cycle the switch happens, the old owner stops driving and the new owner starts, so no two devices drive the bus at once.

Top module: `qae_status_bus`

## Requirements
- R1: After reset, and until a selection naming this device has taken effect, `stat_oe` is 0 and `stat_bus` is high-impedance.
- R2: The device field is bits [7:5] of the selection word and the quadrant index is bits [1:0]. An index of 0, 1, 2 or 3 selects queues 0–7, 8–15, 16–23 or 24–31. Bus bit i carries the flag of queue 8·index + i, so the lowest queue of the quadrant is on bit 0.
- R3: A selection sampled with `sel_stb` high at clock edge k changes the ownership and the quadrant on the bus at edge k+1. Until then the previously loaded quadrant and ownership stay on the bus.
- R4: While this device owns the bus, `stat_bus` shows, after every clock edge, the flags of the selected quadrant as sampled at that edge. Bits are active low: 0 means the queue is almost empty.
- R5: A strobed selection whose device field differs from `local_id` releases the bus (`stat_oe` goes to 0) with the latency of R3 if this device owns it.
- R6: A non-matching strobed selection leaves a device that does not own the bus undriven.
- R7: Bits [4:2] of the selection word have no effect.
- R8: The selection word is ignored in cycles where `sel_stb` is low.
- R9: Strobes on consecutive cycles each take effect one cycle after their capture, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| local_id | input | 3 | Identifier strapped for this device |
| sel_stb | input | 1 | Strobe that captures `sel_word` |
| sel_word | input | 8 | Selection word: device [7:5], unused [4:2], quadrant [1:0] |
| ae_n | input | 32 | Live per-queue almost-empty flags, active low |
| stat_oe | output | 1 | High while this device drives the bus |
| stat_bus | output | 8 | Shared status bus, high-impedance when not owned |

## Verification
Every quadrant index is selected with matching device fields, and the flag inputs are driven with walking zeros and random words. These patterns show that the lane mapping and the per-cycle follow-up are correct for each quadrant. Ownership is passed away with non-matching fields, both while owning and while idle, which tells a correct release apart from one that fires too early or sticks. Selection words are changed without a strobe, the unused middle bits are filled with noise, and strobes are sent back to back. These cases expose a decoder that latches without the strobe, reads the wrong field, or loses a selection in a burst.

// File: rtl/qae_pkg.sv
package qae_pkg;
  localparam int QIDX_W = 2;

  typedef struct packed {
    logic              match;
    logic [QIDX_W-1:0] quad;
  } qae_sel_t;
endpackage

// File: rtl/qae_sel_decode.sv
module qae_sel_decode
  import qae_pkg::*;
#(
  parameter int DEV_W = 3,
  parameter int SEL_W = 8
) (
  input  logic             clk,
  input  logic             rst_s_n,
  input  logic             sel_stb,
  input  logic [SEL_W-1:0] sel_word,
  input  logic [DEV_W-1:0] local_id,
  output logic             pend_valid,
  output qae_sel_t         pend_sel
);
  localparam int DEV_LSB = SEL_W - DEV_W;

  logic     valid_d;
  qae_sel_t sel_d;

  always_comb begin
    valid_d = sel_stb;
    sel_d   = pend_sel;
    if (sel_stb) begin
      sel_d.match = (sel_word[SEL_W-1:DEV_LSB] == local_id);
      sel_d.quad  = sel_word[QIDX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      pend_valid <= 1'b0;
      pend_sel   <= '0;
    end else begin
      pend_valid <= valid_d;
      pend_sel   <= sel_d;
    end
  end
endmodule

// File: rtl/qae_own_ctrl.sv
module qae_own_ctrl
  import qae_pkg::*;
(
  input  logic              clk,
  input  logic              rst_s_n,
  input  logic              pend_valid,
  input  qae_sel_t          pend_sel,
  output logic              own_q,
  output logic [QIDX_W-1:0] quad_q,
  output logic [QIDX_W-1:0] quad_d
);
  logic own_d;

  always_comb begin
    own_d  = own_q;
    quad_d = quad_q;
    if (pend_valid) begin
      own_d  = pend_sel.match;
      quad_d = pend_sel.quad;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      own_q  <= 1'b0;
      quad_q <= '0;
    end else begin
      own_q  <= own_d;
      quad_q <= quad_d;
    end
  end

  AST_OWN_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(own_q) |-> $past(pend_valid)) else $error("ownership without command"); // R1
endmodule

// File: rtl/qae_lane_mux.sv
module qae_lane_mux
  import qae_pkg::*;
#(
  parameter int LANES = 8,
  parameter int QUADS = 4
) (
  input  logic                   clk,
  input  logic                   rst_s_n,
  input  logic [LANES*QUADS-1:0] ae_n,
  input  logic [QIDX_W-1:0]      quad_sel,
  output logic [LANES-1:0]       lane_q
);
  logic [LANES-1:0] lane_d;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [QUADS-1:0] cand;
    for (genvar q = 0; q < QUADS; q++) begin : g_quad
      assign cand[q] = ae_n[q*LANES + i];
    end
    always_comb lane_d[i] = cand[quad_sel];
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) lane_q <= '1;
    else          lane_q <= lane_d;
  end
endmodule

// File: rtl/qae_status_bus.sv
module qae_status_bus
  import qae_pkg::*;
#(
  parameter int DEV_W = 3,
  parameter int SEL_W = 8,
  parameter int LANES = 8,
  parameter int QUADS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [DEV_W-1:0]       local_id,
  input  logic                   sel_stb,
  input  logic [SEL_W-1:0]       sel_word,
  input  logic [LANES*QUADS-1:0] ae_n,
  output logic                   stat_oe,
  output wire  [LANES-1:0]       stat_bus
);
  localparam int DEV_LSB = SEL_W - DEV_W;

  logic [1:0]        rst_pipe;
  logic              rst_s_n;
  logic              pend_valid;
  qae_sel_t          pend_sel;
  logic              own_q;
  logic [QIDX_W-1:0] quad_q;
  logic [QIDX_W-1:0] quad_d;
  logic [LANES-1:0]  lane_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  qae_sel_decode #(.DEV_W(DEV_W), .SEL_W(SEL_W)) u_dec (
    .clk(clk), .rst_s_n(rst_s_n), .sel_stb(sel_stb), .sel_word(sel_word),
    .local_id(local_id), .pend_valid(pend_valid), .pend_sel(pend_sel)
  );

  qae_own_ctrl u_own (
    .clk(clk), .rst_s_n(rst_s_n), .pend_valid(pend_valid), .pend_sel(pend_sel),
    .own_q(own_q), .quad_q(quad_q), .quad_d(quad_d)
  );

  qae_lane_mux #(.LANES(LANES), .QUADS(QUADS)) u_mux (
    .clk(clk), .rst_s_n(rst_s_n), .ae_n(ae_n), .quad_sel(quad_d), .lane_q(lane_q)
  );

  assign stat_oe  = own_q;
  assign stat_bus = own_q ? lane_q : {LANES{1'bz}};

  AST_TAKE_BUS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (sel_stb && sel_word[SEL_W-1:DEV_LSB] == local_id) |=> ##1 stat_oe) else $error("no take"); // R2
  AST_DROP_BUS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (sel_stb && sel_word[SEL_W-1:DEV_LSB] != local_id) |=> ##1 !stat_oe) else $error("no drop"); // R5
  AST_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_s_n)
    (sel_stb && !$past(sel_stb)) |=> $stable(stat_oe)) else $error("early switch"); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!sel_stb ##1 !sel_stb) |=> $stable(stat_oe)) else $error("switch without strobe"); // R8
endmodule

// File: tb/tb_qae_status_bus.sv
module tb_qae_status_bus;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  local_id;
  logic        sel_stb;
  logic [7:0]  sel_word;
  logic [31:0] ae_n;
  logic        stat_oe;
  wire  [7:0]  stat_bus;

  int n_run = 0;
  int n_fail = 0;
  string cur_req = "R1";

  // behavioural model
  bit       m_pv, m_pm, m_own;
  int       m_pq, m_quad;
  bit [7:0] m_data;

  always #4 clk = ~clk;

  qae_status_bus dut (
    .clk(clk), .rst_n(rst_n), .local_id(local_id), .sel_stb(sel_stb),
    .sel_word(sel_word), .ae_n(ae_n), .stat_oe(stat_oe), .stat_bus(stat_bus)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pv = 0; m_pm = 0; m_own = 0; m_pq = 0; m_quad = 0; m_data = 8'hff;
    end else begin
      if (m_pv) begin m_own = m_pm; m_quad = m_pq; end
      m_data = 8'((ae_n >> (8 * m_quad)) & 32'hff);
      m_pv = sel_stb;
      if (sel_stb) begin
        m_pm = (sel_word[7:5] == local_id);
        m_pq = int'(sel_word[1:0]);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_run++;
      if (stat_oe !== m_own) begin
        n_fail++;
        $display("FAIL %s: stat_oe=%b expected %b", cur_req, stat_oe, m_own);
      end else if (m_own) begin
        n_run++;
        if (stat_bus !== m_data) begin
          n_fail++;
          $display("FAIL %s: stat_bus=%h expected %h", cur_req, stat_bus, m_data);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic select(input bit [2:0] dev, input bit [2:0] mid, input bit [1:0] q);
    sel_word = {dev, mid, q};
    sel_stb  = 1'b1;
    step(1);
    sel_stb  = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, expected end");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; local_id = 3'd5; sel_stb = 1'b0; sel_word = 8'h00; ae_n = '1;
    step(3);
    rst_n = 1'b1;
    cur_req = "R1"; step(6);

    // R2: each quadrant, walking zero on the flags
    cur_req = "R2";
    for (int q = 0; q < 4; q++) begin
      select(3'd5, 3'b000, 2'(q));
      for (int b = 0; b < 32; b += 3) begin
        ae_n = ~(32'h1 << b);
        step(1);
      end
    end

    // R3: switch quadrant while the flags differ between quadrants
    cur_req = "R3";
    ae_n = 32'h00ff_a55a;
    select(3'd5, 3'b000, 2'd3);
    step(3);
    select(3'd5, 3'b000, 2'd0);
    step(3);

    // R4: live random flags
    cur_req = "R4";
    select(3'd5, 3'b000, 2'd2);
    for (int i = 0; i < 30; i++) begin
      ae_n = $urandom;
      step(1);
    end

    // R5: release while owning
    cur_req = "R5";
    select(3'd3, 3'b000, 2'd3);
    step(4);

    // R6: non-matching while idle
    cur_req = "R6";
    select(3'd1, 3'b000, 2'd1);
    select(3'd7, 3'b000, 2'd0);
    step(4);

    // R7: middle bits carry noise
    cur_req = "R7";
    ae_n = 32'h1234_abcd;
    select(3'd5, 3'b111, 2'd1);
    step(3);
    select(3'd5, 3'b101, 2'd3);
    step(3);

    // R8: word changes without strobe
    cur_req = "R8";
    for (int i = 0; i < 8; i++) begin
      sel_word = 8'($urandom);
      ae_n = $urandom;
      step(1);
    end
    sel_word = 8'h00;
    step(2);

    // R9: back-to-back strobes
    cur_req = "R9";
    sel_stb = 1'b1;
    sel_word = {3'd5, 3'b000, 2'd0}; ae_n = $urandom; step(1);
    sel_word = {3'd2, 3'b000, 2'd1}; ae_n = $urandom; step(1);
    sel_word = {3'd5, 3'b000, 2'd2}; ae_n = $urandom; step(1);
    sel_word = {3'd5, 3'b010, 2'd3}; ae_n = $urandom; step(1);
    sel_stb = 1'b0;
    for (int i = 0; i < 5; i++) begin
      ae_n = $urandom;
      step(1);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule